// File: doc/BRIEF.md
# Branch Outcome Hint Queue

This block links a look-ahead core, which runs a reduced copy of the program ahead of the real one, to the trailing main core. The look-ahead core commits conditional branches in program order. Each branch outcome goes into a direction queue, one entry per dynamic basic block. Wider side data (branch targets, prefetch addresses, reuse values) goes into a second queue. When side data is written, the newest direction entry is flagged to say that a group of side entries belongs to it. The main core's fetch unit takes its branch directions from the head of the direction queue. When the queue is empty, fetch stalls; it does not fall back to a local predictor.

A flagged entry can be dequeued. After that, the side entries of its group are presented in order, up to the one marked as the last of the group. Direction delivery waits until that group is drained. A prefetch address therefore leaves the block only when its branch is consumed, which times the prefetch to the main core's progress. A target entry at the side head replaces the main core's local target guess. The number of unread direction entries is the look-ahead distance. A full direction queue holds the producer back.

When a resolved branch disagrees with the direction the queue supplied, the block flushes both queues in one cycle. It then holds a reboot window of fixed length. During that window, producer pushes are refused, and architectural register words from the main core are forwarded to the look-ahead core.

Top module: `branch_hint_link`

## Requirements
- R1: After reset, `ahead_depth` is 0, `mc_pred_valid`, `mc_side_valid` and `reboot_busy` are 0, `lq_br_ready` is 1, and `lq_side_ready` is 0 while `lq_br_valid` is 0.
- R2: Directions are delivered in the order they were pushed, and `ahead_depth` equals the number of pushed, undelivered directions, including across pointer wrap.
- R3: With DIR_DEPTH unread entries, `lq_br_ready` is 0. With none, `mc_pred_valid` is 0, so fetch must stall.
- R4: An accepted side push sets the footnote flag of the newest direction entry: the entry pushed in the same cycle if there is one, otherwise the newest unread entry. If that entry is being dequeued in the same cycle, `mc_pred_more` already shows 1. `lq_side_ready` is 0 when there is no unread entry and no direction push.
- R5: After a direction with `mc_pred_more`=1 is taken, `mc_pred_valid` stays 0 until the side entry with `mc_side_last`=1 is taken. The side entries come out in push order.
- R6: Side entries are never presented before their direction entry is taken. Kind encoding: 0 target, 1 prefetch address, 2 reuse value, 3 register copy. Taking a kind-1 entry raises `mc_pf_valid` with `mc_pf_addr` equal to its payload in the same cycle.
- R7: `mc_fetch_target` equals the side payload, and `mc_target_from_hint` is 1, while a kind-0 side entry is presented. Otherwise `mc_fetch_target` equals `mc_local_target` and `mc_target_from_hint` is 0.
- R8: A resolution with `mc_res_taken` different from `mc_res_pred_taken` flushes both queues. In the next cycle `ahead_depth` is 0, nothing is presented, and `reboot_busy` is 1 for exactly REBOOT_CYCLES cycles.
- R9: During the cycle of a mismatch and while `reboot_busy` is 1, both producer ready signals are 0 and pushes leave `ahead_depth` unchanged. Pushes are accepted again after the window.
- R10: A register word offered on `mc_regs_*` while `reboot_busy` is 1 appears on `lq_regs_*` one cycle later. Outside the window, `lq_regs_valid` stays 0.
- R11: A mismatch during a reboot window restarts the window at its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lq_br_valid | input | 1 | Look-ahead core offers a committed branch outcome |
| lq_br_taken | input | 1 | Offered outcome, 1 = taken |
| lq_br_ready | output | 1 | Direction push accepted this cycle |
| lq_side_valid | input | 1 | Look-ahead core offers a side word |
| lq_side_kind | input | 2 | Side word kind (0 target, 1 prefetch, 2 reuse, 3 register copy) |
| lq_side_last | input | 1 | Side word closes its group |
| lq_side_data | input | 64 | Side word payload |
| lq_side_ready | output | 1 | Side push accepted this cycle |
| mc_pred_valid | output | 1 | A direction is available to fetch |
| mc_pred_taken | output | 1 | Head direction |
| mc_pred_more | output | 1 | Head direction has a side group attached |
| mc_pred_ready | input | 1 | Fetch takes the head direction |
| mc_side_valid | output | 1 | A side word of the open group is presented |
| mc_side_kind | output | 2 | Kind of the presented side word |
| mc_side_last | output | 1 | Presented word closes the group |
| mc_side_data | output | 64 | Presented side payload |
| mc_side_ready | input | 1 | Main core takes the side word |
| mc_local_target | input | 64 | Main core's own target guess |
| mc_fetch_target | output | 64 | Target chosen for fetch |
| mc_target_from_hint | output | 1 | Fetch target comes from a hint |
| mc_pf_valid | output | 1 | Prefetch request released |
| mc_pf_addr | output | 64 | Prefetch address |
| mc_res_valid | input | 1 | A queue-predicted branch resolved |
| mc_res_taken | input | 1 | Resolved direction |
| mc_res_pred_taken | input | 1 | Direction the queue had supplied for it |
| mc_regs_valid | input | 1 | Main core offers an architectural register word |
| mc_regs_data | input | 64 | Register word |
| lq_regs_valid | output | 1 | Register word delivered to the look-ahead core |
| lq_regs_data | output | 64 | Delivered register word |
| reboot_busy | output | 1 | Reboot window active |
| ahead_depth | output | clog2(DIR_DEPTH+1) | Unread direction entries |

## Verification
The hardest situation to reach is a side push that lands in the same cycle the newest direction entry leaves the queue. If the push arrives one cycle early or late, the flag is either stored normally or belongs to no entry. The stimulus therefore leaves exactly one unflagged entry queued and then, in one cycle, asserts the side push together with the fetch take. A mismatch that arrives partway through a running reboot window is reached by timing a second resolution a few cycles after the first. The window is then measured to its end.

// File: rtl/hq_pkg.sv
// Shared types for the branch hint link.
// Assumes a fixed 64-bit side payload.
package hq_pkg;
    localparam int SIDE_W = 64;

    typedef enum logic [1:0] {
        HK_TARGET   = 2'd0,
        HK_PREFETCH = 2'd1,
        HK_REUSE    = 2'd2,
        HK_REGCOPY  = 2'd3
    } hint_kind_e;

    typedef struct packed {
        logic       last;
        hint_kind_e kind;
        logic [SIDE_W-1:0] data;
    } side_word_t;
endpackage

// File: rtl/hq_fifo.sv
// Generic circular FIFO with a one-cycle flush.
// Assumes the caller never pushes when full or pops when empty.
module hq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= push_data;
    end

    // Pointer and fill tracking with flush priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= step_ptr(wr_ptr);
            if (pop)  rd_ptr <= step_ptr(rd_ptr);
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign head  = store[rd_ptr];
    assign empty = (fill == '0);
    assign full  = (fill == CW'(DEPTH));
endmodule

// File: rtl/hq_dir_queue.sv
// Direction queue: one outcome bit and one footnote flag per entry.
// A mark request flags the newest entry (the one written this cycle if any).
// Assumes mark is only raised when an entry exists or is being pushed.
module hq_dir_queue #(
    parameter int DEPTH = 512,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          push_taken,
    input  logic          mark,
    input  logic          pop,
    output logic          head_taken,
    output logic          head_more,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic          dir_bit  [DEPTH];
    logic          foot_bit [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, newest;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign newest = (wr_ptr == '0) ? AW'(DEPTH - 1) : wr_ptr - 1'b1;

    // Outcome and footnote storage; a mark without a push flags the newest entry.
    always_ff @(posedge clk) begin
        if (push) begin
            dir_bit[wr_ptr]  <= push_taken;
            foot_bit[wr_ptr] <= mark;
        end else if (mark) begin
            foot_bit[newest] <= 1'b1;
        end
    end

    // Pointer and occupancy tracking with flush priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step_ptr(wr_ptr);
            if (pop)  rd_ptr <= step_ptr(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head view, with the same-cycle mark forwarded onto a lone head entry.
    always_comb begin
        head_taken = dir_bit[rd_ptr];
        head_more  = foot_bit[rd_ptr] | (mark && !push && (rd_ptr == newest));
    end

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/hq_reboot_ctrl.sv
// Reboot window timer and register-copy forwarding stage.
// A start pulse (re)loads the window to its full length.
module hq_reboot_ctrl #(
    parameter int CYCLES = 64,
    parameter int W      = 64,
    localparam int TW    = $clog2(CYCLES + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    output logic         busy,
    input  logic         copy_in_valid,
    input  logic [W-1:0] copy_in_data,
    output logic         copy_out_valid,
    output logic [W-1:0] copy_out_data
);
    logic [TW-1:0] remain;

    // Window countdown; a new start restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)            remain <= '0;
        else if (start)        remain <= TW'(CYCLES);
        else if (remain != '0) remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    // Register words pass one stage toward the look-ahead core during the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            copy_out_valid <= 1'b0;
            copy_out_data  <= '0;
        end else begin
            copy_out_valid <= copy_in_valid && busy;
            if (copy_in_valid && busy) copy_out_data <= copy_in_data;
        end
    end
endmodule

// File: rtl/branch_hint_link.sv
// Top level: direction queue, side-data queue, group sequencing and reboot.
// Assumes resolutions only report branches whose direction came from this block.
module branch_hint_link
    import hq_pkg::*;
#(
    parameter int DIR_DEPTH     = 512,
    parameter int SIDE_DEPTH    = 128,
    parameter int REBOOT_CYCLES = 64,
    localparam int DEPTH_W      = $clog2(DIR_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lq_br_valid,
    input  logic               lq_br_taken,
    output logic               lq_br_ready,
    input  logic               lq_side_valid,
    input  logic [1:0]         lq_side_kind,
    input  logic               lq_side_last,
    input  logic [SIDE_W-1:0]  lq_side_data,
    output logic               lq_side_ready,
    output logic               mc_pred_valid,
    output logic               mc_pred_taken,
    output logic               mc_pred_more,
    input  logic               mc_pred_ready,
    output logic               mc_side_valid,
    output logic [1:0]         mc_side_kind,
    output logic               mc_side_last,
    output logic [SIDE_W-1:0]  mc_side_data,
    input  logic               mc_side_ready,
    input  logic [SIDE_W-1:0]  mc_local_target,
    output logic [SIDE_W-1:0]  mc_fetch_target,
    output logic               mc_target_from_hint,
    output logic               mc_pf_valid,
    output logic [SIDE_W-1:0]  mc_pf_addr,
    input  logic               mc_res_valid,
    input  logic               mc_res_taken,
    input  logic               mc_res_pred_taken,
    input  logic               mc_regs_valid,
    input  logic [SIDE_W-1:0]  mc_regs_data,
    output logic               lq_regs_valid,
    output logic [SIDE_W-1:0]  lq_regs_data,
    output logic               reboot_busy,
    output logic [DEPTH_W-1:0] ahead_depth
);
    logic       mismatch, busy;
    logic       dir_empty, dir_full, head_taken, head_more;
    logic       side_empty, side_full;
    logic       br_fire, side_fire, pred_fire, side_take;
    logic       group_open;
    side_word_t side_in, side_head;

    // A resolved direction that disagrees with the supplied one starts a reboot.
    assign mismatch = mc_res_valid && (mc_res_taken != mc_res_pred_taken);

    // Producer acceptance: closed during a mismatch and during the reboot window.
    always_comb begin
        lq_br_ready   = !busy && !mismatch && !dir_full;
        lq_side_ready = !busy && !mismatch && !side_full && (!dir_empty || lq_br_valid);
        br_fire       = lq_br_valid && lq_br_ready;
        side_fire     = lq_side_valid && lq_side_ready;
        side_in       = '{last: lq_side_last, kind: hint_kind_e'(lq_side_kind), data: lq_side_data};
    end

    hq_dir_queue #(.DEPTH(DIR_DEPTH)) u_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (mismatch),
        .push       (br_fire),
        .push_taken (lq_br_taken),
        .mark       (side_fire),
        .pop        (pred_fire),
        .head_taken (head_taken),
        .head_more  (head_more),
        .empty      (dir_empty),
        .full       (dir_full),
        .count      (ahead_depth)
    );

    hq_fifo #(.W($bits(side_word_t)), .DEPTH(SIDE_DEPTH)) u_side (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (mismatch),
        .push      (side_fire),
        .push_data (side_in),
        .pop       (side_take),
        .head      (side_head),
        .empty     (side_empty),
        .full      (side_full)
    );

    hq_reboot_ctrl #(.CYCLES(REBOOT_CYCLES), .W(SIDE_W)) u_reboot (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (mismatch),
        .busy           (busy),
        .copy_in_valid  (mc_regs_valid),
        .copy_in_data   (mc_regs_data),
        .copy_out_valid (lq_regs_valid),
        .copy_out_data  (lq_regs_data)
    );

    // Consumer view: directions while no group is open, side words while one is.
    always_comb begin
        mc_pred_valid = !busy && !group_open && !dir_empty;
        mc_pred_taken = head_taken;
        mc_pred_more  = head_more;
        pred_fire     = mc_pred_valid && mc_pred_ready;
        mc_side_valid = !busy && group_open && !side_empty;
        mc_side_kind  = side_head.kind;
        mc_side_last  = side_head.last;
        mc_side_data  = side_head.data;
        side_take     = mc_side_valid && mc_side_ready;
    end

    // Hint decoding: target override and just-in-time prefetch release.
    always_comb begin
        mc_target_from_hint = mc_side_valid && (side_head.kind == HK_TARGET);
        mc_fetch_target     = mc_target_from_hint ? side_head.data : mc_local_target;
        mc_pf_valid         = side_take && (side_head.kind == HK_PREFETCH);
        mc_pf_addr          = side_head.data;
    end

    // Group state: opened by a flagged direction, closed by the last side word.
    always_ff @(posedge clk) begin
        if (!rst_n || mismatch)          group_open <= 1'b0;
        else if (pred_fire && head_more) group_open <= 1'b1;
        else if (side_take && side_head.last) group_open <= 1'b0;
    end

    assign reboot_busy = busy;
endmodule

// File: rtl/hq_checker.sv
// Port-level properties of the branch hint link, bound to the top module.
module hq_checker #(
    parameter int DIR_DEPTH = 512,
    parameter int DW        = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lq_br_valid,
    input logic          lq_br_ready,
    input logic          lq_side_ready,
    input logic          mc_pred_valid,
    input logic          mc_side_valid,
    input logic          mc_res_valid,
    input logic          mc_res_taken,
    input logic          mc_res_pred_taken,
    input logic          mc_regs_valid,
    input logic          lq_regs_valid,
    input logic          reboot_busy,
    input logic [DW-1:0] ahead_depth
);
    logic mism;
    assign mism = mc_res_valid && (mc_res_taken != mc_res_pred_taken);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ahead_depth <= DW'(DIR_DEPTH)); // R3
    AST_FULL_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
        (ahead_depth == DW'(DIR_DEPTH)) |-> !lq_br_ready); // R3
    AST_EMPTY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ahead_depth == '0) |-> !mc_pred_valid); // R3
    AST_DEPTH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !mism |=> ({1'b0, ahead_depth} <= {1'b0, $past(ahead_depth)} + 1'b1)
              && ({1'b0, $past(ahead_depth)} <= {1'b0, ahead_depth} + 1'b1)); // R2
    AST_SIDE_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        lq_side_ready |-> (ahead_depth != '0 || lq_br_valid)); // R4
    AST_GROUP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        mc_side_valid |-> !mc_pred_valid); // R5
    AST_FLUSH_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mism |=> (ahead_depth == '0) && reboot_busy && !mc_side_valid); // R8
    AST_BUSY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (reboot_busy || mism) |-> !lq_br_ready && !lq_side_ready); // R9
    AST_COPY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        lq_regs_valid |-> $past(reboot_busy) && $past(mc_regs_valid)); // R10
endmodule

bind branch_hint_link hq_checker #(.DIR_DEPTH(DIR_DEPTH), .DW(DEPTH_W)) u_hq_checker (
    .clk               (clk),
    .rst_n             (rst_n),
    .lq_br_valid       (lq_br_valid),
    .lq_br_ready       (lq_br_ready),
    .lq_side_ready     (lq_side_ready),
    .mc_pred_valid     (mc_pred_valid),
    .mc_side_valid     (mc_side_valid),
    .mc_res_valid      (mc_res_valid),
    .mc_res_taken      (mc_res_taken),
    .mc_res_pred_taken (mc_res_pred_taken),
    .mc_regs_valid     (mc_regs_valid),
    .lq_regs_valid     (lq_regs_valid),
    .reboot_busy       (reboot_busy),
    .ahead_depth       (ahead_depth)
);

// File: tb/test_branch_hint_link.sv
// Self-checking bench on a small configuration of the branch hint link.
module test_branch_hint_link;
    localparam int DD = 8;
    localparam int SD = 4;
    localparam int RB = 6;
    localparam int DW = $clog2(DD + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lq_br_valid = 0, lq_br_taken = 0, lq_br_ready;
    logic        lq_side_valid = 0, lq_side_last = 0, lq_side_ready;
    logic [1:0]  lq_side_kind = 0;
    logic [63:0] lq_side_data = 0;
    logic        mc_pred_valid, mc_pred_taken, mc_pred_more, mc_pred_ready = 0;
    logic        mc_side_valid, mc_side_last, mc_side_ready = 0;
    logic [1:0]  mc_side_kind;
    logic [63:0] mc_side_data, mc_fetch_target, mc_pf_addr, lq_regs_data;
    logic [63:0] mc_local_target = 64'h1111_0000;
    logic        mc_target_from_hint, mc_pf_valid, lq_regs_valid, reboot_busy;
    logic        mc_res_valid = 0, mc_res_taken = 0, mc_res_pred_taken = 0;
    logic        mc_regs_valid = 0;
    logic [63:0] mc_regs_data = 0;
    logic [DW-1:0] ahead_depth;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    branch_hint_link #(.DIR_DEPTH(DD), .SIDE_DEPTH(SD), .REBOOT_CYCLES(RB)) i_branch_hint_link (
        .clk(clk), .rst_n(rst_n),
        .lq_br_valid(lq_br_valid), .lq_br_taken(lq_br_taken), .lq_br_ready(lq_br_ready),
        .lq_side_valid(lq_side_valid), .lq_side_kind(lq_side_kind), .lq_side_last(lq_side_last),
        .lq_side_data(lq_side_data), .lq_side_ready(lq_side_ready),
        .mc_pred_valid(mc_pred_valid), .mc_pred_taken(mc_pred_taken), .mc_pred_more(mc_pred_more),
        .mc_pred_ready(mc_pred_ready),
        .mc_side_valid(mc_side_valid), .mc_side_kind(mc_side_kind), .mc_side_last(mc_side_last),
        .mc_side_data(mc_side_data), .mc_side_ready(mc_side_ready),
        .mc_local_target(mc_local_target), .mc_fetch_target(mc_fetch_target),
        .mc_target_from_hint(mc_target_from_hint),
        .mc_pf_valid(mc_pf_valid), .mc_pf_addr(mc_pf_addr),
        .mc_res_valid(mc_res_valid), .mc_res_taken(mc_res_taken),
        .mc_res_pred_taken(mc_res_pred_taken),
        .mc_regs_valid(mc_regs_valid), .mc_regs_data(mc_regs_data),
        .lq_regs_valid(lq_regs_valid), .lq_regs_data(lq_regs_data),
        .reboot_busy(reboot_busy), .ahead_depth(ahead_depth)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance to 5 ns after the next rising edge.
    task automatic clk_step();
        @(posedge clk);
        #5;
    endtask

    task automatic push_dir(input logic t);
        lq_br_valid = 1'b1; lq_br_taken = t;
        #2;
        clk_step();
        lq_br_valid = 1'b0;
    endtask

    task automatic push_side(input logic [1:0] k, input logic l, input logic [63:0] d);
        lq_side_valid = 1'b1; lq_side_kind = k; lq_side_last = l; lq_side_data = d;
        #2;
        chk("R4 side push accepted", {63'd0, lq_side_ready}, 64'd1);
        clk_step();
        lq_side_valid = 1'b0;
    endtask

    task automatic pop_dir(input string req, input logic exp_t, input logic exp_m);
        mc_pred_ready = 1'b1;
        #2;
        chk(req, {62'd0, mc_pred_valid, mc_pred_taken}, {62'd0, 1'b1, exp_t});
        chk("R4 footnote flag", {63'd0, mc_pred_more}, {63'd0, exp_m});
        clk_step();
        mc_pred_ready = 1'b0;
    endtask

    task automatic mismatch_now();
        mc_res_valid = 1'b1; mc_res_taken = 1'b1; mc_res_pred_taken = 1'b0;
        #2;
        chk("R9 ready closed on mismatch", {62'd0, lq_br_ready, lq_side_ready}, 64'd0);
        clk_step();
        mc_res_valid = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) clk_step();
        rst_n = 1'b1;
        #2;
        // R1 reset state
        chk("R1 depth", 64'(ahead_depth), 64'd0);
        chk("R1 pred/side/busy", {61'd0, mc_pred_valid, mc_side_valid, reboot_busy}, 64'd0);
        chk("R1 readies", {62'd0, lq_br_ready, lq_side_ready}, 64'b10);
        clk_step();

        // R2/R3 sweep: push k entries then drain them, for every k, so pointers wrap.
        for (int k = 1; k <= DD; k++) begin
            for (int i = 0; i < k; i++) begin
                chk("R3 not full", {63'd0, lq_br_ready}, 64'd1);
                push_dir(1'(((k * 3 + i * 5) >> 1) & 1));
                chk("R2 depth grows", 64'(ahead_depth), 64'(i + 1));
            end
            if (k == DD) chk("R3 full backpressure", {63'd0, lq_br_ready}, 64'd0);
            for (int i = 0; i < k; i++) begin
                pop_dir("R2 order", 1'(((k * 3 + i * 5) >> 1) & 1), 1'b0);
                chk("R2 depth shrinks", 64'(ahead_depth), 64'(k - i - 1));
            end
            chk("R3 empty stall", {63'd0, mc_pred_valid}, 64'd0);
        end

        // R4 side refused with no entry, R6 hold-off, R5 group drain, R7 target.
        #2;
        chk("R4 side refused without entry", {63'd0, lq_side_ready}, 64'd0);
        push_dir(1'b1);
        push_side(2'd1, 1'b0, 64'hABC0);
        push_side(2'd0, 1'b1, 64'h7700);
        push_dir(1'b0);
        chk("R2 depth with group", 64'(ahead_depth), 64'd2);
        chk("R6 no side before dequeue", {63'd0, mc_side_valid}, 64'd0);
        chk("R7 local target", mc_fetch_target, mc_local_target);
        pop_dir("R5 flagged head", 1'b1, 1'b1);
        #2;
        chk("R5 directions held", {63'd0, mc_pred_valid}, 64'd0);
        chk("R6 prefetch word", {61'd0, mc_side_valid, mc_side_kind}, {61'd0, 1'b1, 2'd1});
        mc_side_ready = 1'b1;
        #1;
        chk("R6 prefetch released", {63'd0, mc_pf_valid}, 64'd1);
        chk("R6 prefetch addr", mc_pf_addr, 64'hABC0);
        clk_step();
        #2;
        chk("R7 hint target", mc_fetch_target, 64'h7700);
        chk("R7 from hint", {62'd0, mc_target_from_hint, mc_side_last}, 64'b11);
        chk("R6 no prefetch for target", {63'd0, mc_pf_valid}, 64'd0);
        clk_step();
        mc_side_ready = 1'b0;
        #2;
        chk("R5 group closed", {62'd0, mc_side_valid, mc_pred_valid}, 64'b01);
        chk("R7 back to local", {63'd0, mc_target_from_hint}, 64'd0);
        pop_dir("R2 after group", 1'b0, 1'b0);

        // R4 same-cycle push and mark onto an empty queue.
        lq_br_valid = 1'b1; lq_br_taken = 1'b1;
        push_side(2'd2, 1'b1, 64'h55);
        lq_br_valid = 1'b0;
        pop_dir("R4 same-cycle mark", 1'b1, 1'b1);
        mc_side_ready = 1'b1; #2;
        chk("R5 reuse word", mc_side_data, 64'h55);
        clk_step(); mc_side_ready = 1'b0;

        // R4 mark forwarded onto a lone head being dequeued in the same cycle.
        push_dir(1'b0);
        lq_side_valid = 1'b1; lq_side_kind = 2'd1; lq_side_last = 1'b1; lq_side_data = 64'h99;
        mc_pred_ready = 1'b1;
        #2;
        chk("R4 forwarded flag", {62'd0, mc_pred_valid, mc_pred_more}, 64'b11);
        clk_step();
        lq_side_valid = 1'b0; mc_pred_ready = 1'b0;
        mc_side_ready = 1'b1; #2;
        chk("R6 forwarded group prefetch", {63'd0, mc_pf_valid}, 64'd1);
        chk("R6 forwarded addr", mc_pf_addr, 64'h99);
        clk_step(); mc_side_ready = 1'b0;

        // R8/R9/R10 reboot.
        push_dir(1'b1);
        push_side(2'd1, 1'b1, 64'h42);
        push_dir(1'b0);
        mismatch_now();
        #2;
        chk("R8 flushed", 64'(ahead_depth), 64'd0);
        chk("R8 nothing presented", {62'd0, mc_pred_valid, mc_side_valid}, 64'd0);
        for (int c = 0; c < RB; c++) begin
            chk("R8 window busy", {63'd0, reboot_busy}, 64'd1);
            lq_br_valid = 1'b1; mc_regs_valid = 1'b1; mc_regs_data = 64'(c * 7 + 3);
            #1;
            chk("R9 ready closed", {62'd0, lq_br_ready, lq_side_ready}, 64'd0);
            clk_step();
            chk("R9 push ignored", 64'(ahead_depth), 64'd0);
            chk("R10 copy valid", {63'd0, lq_regs_valid}, 64'd1);
            chk("R10 copy data", lq_regs_data, 64'(c * 7 + 3));
        end
        lq_br_valid = 1'b0;
        #2;
        chk("R8 window length", {63'd0, reboot_busy}, 64'd0);
        clk_step();
        mc_regs_valid = 1'b0;
        chk("R10 no copy outside window", {63'd0, lq_regs_valid}, 64'd0);
        push_dir(1'b0);
        chk("R9 accepted after window", 64'(ahead_depth), 64'd1);
        pop_dir("R8 side flushed", 1'b0, 1'b0);
        #2;
        chk("R8 stale side gone", {63'd0, mc_side_valid}, 64'd0);

        // R11 restart.
        mismatch_now();
        clk_step(); clk_step(); clk_step();
        mismatch_now();
        for (int c = 0; c < RB; c++) begin
            chk("R11 restarted window", {63'd0, reboot_busy}, 64'd1);
            clk_step();
        end
        chk("R11 window end", {63'd0, reboot_busy}, 64'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule